// File: doc/BRIEF.md
# Receive Byte Queue with Trigger Interrupt

This block sits between a serial receive shifter and the host bus of a UART. Each received byte is pushed into a small first-in-first-out queue. The host drains the queue with read strobes. An interrupt level tells the host that enough bytes are waiting. The threshold is chosen by a 2-bit code, so the host is interrupted once per batch of bytes instead of once per byte.

Some bytes may sit below the threshold with no new traffic arriving. A character-time idle counter catches this case and raises a timeout flag, and the timeout flag also forces the interrupt high. When queueing is switched off, the block holds a single byte and interrupts on every character. A flush pulse empties the queue in one cycle. A sticky flag records any byte that was lost because the queue was full.

Top module: `rx_trig_fifo`

## Requirements
- R1: The queue holds up to 16 bytes and returns them in arrival order. `fill_count` shows the current occupancy (0 to 16). `rd_data` shows the oldest byte, and `rd_strobe` removes it on the next clock edge.
- R2: With `fifo_en` high, `trig_code` selects the trigger level: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. `data_irq` is high whenever occupancy is at or above the selected level.
- R3: Bytes that arrive after the trigger level is reached are still stored, until all 16 entries are used.
- R4: `data_irq` stays high until occupancy falls below the trigger level. A single read from a queue that stays at or above the level does not clear it.
- R5: With `fifo_en` high and at least one byte stored, four `char_tick` pulses with no push and no read set `timeout_flag` in the cycle after the fourth pulse. `data_irq` is high while `timeout_flag` is high.
- R6: Any push or read restarts the idle count. `timeout_flag` is low in the cycle after a read.
- R7: With `fifo_en` low, the block holds one byte, and `data_irq` is high whenever that byte is present.
- R8: A `flush` pulse, or any change of `fifo_en`, empties the queue at the next edge and clears `overrun_flag`. A push in the same cycle as a flush is discarded.
- R9: A push while the queue is at capacity, with no read in the same cycle, is dropped and leaves the occupancy unchanged. It sets `overrun_flag`, which stays high until a flush.
- R10: A read strobe while the queue is empty has no effect, and occupancy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Byte from the receive shifter is valid |
| push_data | input | 8 | Received byte |
| rd_strobe | input | 1 | Host read: remove the oldest byte |
| flush | input | 1 | Empty the queue |
| fifo_en | input | 1 | 1: 16-entry queue, 0: single holding byte |
| trig_code | input | 2 | Trigger level select |
| char_tick | input | 1 | One pulse per character time |
| rd_data | output | 8 | Oldest stored byte |
| fill_count | output | 5 | Current occupancy |
| data_irq | output | 1 | Data-available interrupt level |
| timeout_flag | output | 1 | Idle timeout with data pending |
| overrun_flag | output | 1 | Sticky: a byte was dropped |

## Verification
The bench builds the block with its default parameters: 16 entries, 8-bit bytes and an idle window of 4 ticks. Under these values all four trigger levels (1, 4, 8 and 14) can be reached with a few dozen pushes. Full capacity and the overrun drop can be hit in one burst, and the idle timeout can be provoked and then restarted within a handful of tick pulses. A scoreboard holds the bytes in expected order and checks every read against the front of that queue. The bench also checks the occupancy, the interrupt level, the timeout flag and the overrun flag at each step.

// File: rtl/rxq_pkg.sv
// Package: shared helpers for the receive byte queue.
// Assumes the queue depth is at least 4 so that every trigger level is nonzero.
package rxq_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Trigger level for a 2-bit code, scaled to the queue depth
    // (depth 16 gives 1, 4, 8, 14).
    function automatic int unsigned trig_level(input int unsigned code, input int unsigned depth);
        case (code)
            0:       return 1;
            1:       return depth / 4;
            2:       return depth / 2;
            default: return depth - 2;
        endcase
    endfunction
endpackage

// File: rtl/rxq_store.sv
// Storage: circular byte buffer with read/write pointers, an occupancy count
// and a sticky overrun flag.
// Assumes: cap <= DEPTH. clear has priority over push and pop. A push is
// accepted at capacity only when a pop happens in the same cycle.
module rxq_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    input  logic [CW-1:0] cap,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          overrun,
    output logic          pop_ok
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          push_ok;

    // Accept or reject this cycle's push and pop.
    always_comb begin
        pop_ok  = pop && !clear && (count != '0);
        push_ok = push && !clear && ((count < cap) || pop_ok);
    end

    assign rd_data = mem[rd_ptr];

    // Write accepted bytes into the buffer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Advance the pointers and the occupancy; clear empties everything.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    // Sticky record of a dropped byte; only clear removes it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)       overrun <= 1'b0;
        else if (push && !push_ok) overrun <= 1'b1;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R1
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0) && !overrun); // R8
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clear && count >= cap) |=> (count == $past(count)) && overrun); // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clear) |=> overrun); // R9
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == '0) |=> (count == '0)); // R10
endmodule

// File: rtl/rxq_idle.sv
// Idle timer: counts character ticks while data waits and nothing moves,
// and reports a timeout once IDLE ticks have passed.
// Assumes: activity covers every push, accepted pop and clear.
module rxq_idle #(
    parameter int IDLE = 4,
    localparam int TW  = $clog2(IDLE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic occupied,
    input  logic activity,
    input  logic tick,
    output logic timeout
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [TW-1:0] idle_cnt;

    // Restart on activity or an empty queue; otherwise count ticks up to IDLE.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !occupied || activity) idle_cnt <= '0;
        else if (tick && idle_cnt != TW'(IDLE))          idle_cnt <= idle_cnt + 1'b1;
    end

    assign timeout = enable && occupied && (idle_cnt == TW'(IDLE));

    AST_TO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> !timeout); // R6
    AST_TO_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!timeout && !tick) |=> !timeout); // R5
endmodule

// File: rtl/rx_trig_fifo.sv
// Top: receive byte queue with a programmable trigger interrupt and an idle
// timeout. Selects the capacity and trigger level from the mode inputs, and
// empties the queue on flush or on a change of fifo_en.
// Assumes: push_valid is a single-cycle pulse per received byte; char_tick is
// a single-cycle pulse per character time.
module rx_trig_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int IDLE  = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [W-1:0]  push_data,
    input  logic          rd_strobe,
    input  logic          flush,
    input  logic          fifo_en,
    input  logic [1:0]    trig_code,
    input  logic          char_tick,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] fill_count,
    output logic          data_irq,
    output logic          timeout_flag,
    output logic          overrun_flag
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [CW-1:0] lvl [4];
    logic [CW-1:0] trig, cap;
    logic          en_q, clear, pop_ok;

    // Table of trigger levels, one entry per code.
    for (genvar g = 0; g < 4; g++) begin : g_lvl
        assign lvl[g] = CW'(rxq_pkg::trig_level(g, DEPTH));
    end

    // Remember the last mode so that a mode change can flush the queue.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fifo_en;
    end

    // Pick capacity and trigger level for the current mode.
    always_comb begin
        clear = flush || (fifo_en != en_q);
        cap   = fifo_en ? CW'(DEPTH) : CW'(1);
        trig  = fifo_en ? lvl[trig_code] : CW'(1);
    end

    rxq_store #(.W(W), .DEPTH(DEPTH)) i_store (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .push(push_valid), .push_data(push_data), .pop(rd_strobe),
        .cap(cap), .rd_data(rd_data), .count(fill_count),
        .overrun(overrun_flag), .pop_ok(pop_ok)
    );

    rxq_idle #(.IDLE(IDLE)) i_idle (
        .clk(clk), .rst_n(rst_n), .enable(fifo_en),
        .occupied(fill_count != '0),
        .activity(push_valid || pop_ok || clear),
        .tick(char_tick), .timeout(timeout_flag)
    );

    // Interrupt level: trigger reached, or data stranded by the idle timeout.
    assign data_irq = (fill_count >= trig) || timeout_flag;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_irq && !timeout_flag && !rd_strobe && !clear && $stable(trig_code)) |=> data_irq); // R4
    AST_TO_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |-> data_irq && (fill_count != '0)); // R5
    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !clear) |-> fill_count <= CW'(1)); // R7
endmodule

// File: tb/test_rx_trig_fifo.sv
module test_rx_trig_fifo;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 0, rst_n = 0;
    logic       push_valid = 0, rd_strobe = 0, flush = 0, fifo_en = 0, char_tick = 0;
    logic [7:0] push_data = 0;
    logic [1:0] trig_code = 0;
    logic [7:0] rd_data;
    logic [4:0] fill_count;
    logic       data_irq, timeout_flag, overrun_flag;

    int   n_tests = 0, n_fail = 0;
    bit   done = 0;
    byte unsigned exp_q[$];

    rx_trig_fifo i_rx_trig_fifo (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .rd_strobe(rd_strobe), .flush(flush), .fifo_en(fifo_en), .trig_code(trig_code),
        .char_tick(char_tick), .rd_data(rd_data), .fill_count(fill_count),
        .data_irq(data_irq), .timeout_flag(timeout_flag), .overrun_flag(overrun_flag)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Driver: pushes one byte and records it in the scoreboard if it fits.
    task automatic push_byte(input byte unsigned b);
        int cap_m = fifo_en ? 16 : 1;
        if (exp_q.size() < cap_m) exp_q.push_back(b);
        push_valid = 1;
        push_data  = b;
        step();
        push_valid = 0;
    endtask

    task automatic pop_byte();
        rd_strobe = 1;
        step();
        rd_strobe = 0;
    endtask

    task automatic tick();
        char_tick = 1;
        step();
        char_tick = 0;
    endtask

    task automatic do_flush();
        flush = 1;
        exp_q.delete();
        step();
        flush = 0;
    endtask

    // Monitor: compares each read against the front of the scoreboard (R1).
    always @(negedge clk) begin
        if (rst_n && rd_strobe && !flush && exp_q.size() > 0) begin
            automatic byte unsigned e = exp_q.pop_front();
            chk(rd_data == e, "R1 read order", rd_data, e);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        chk(fill_count == 0, "R1 reset count", fill_count, 0);
        chk(data_irq == 0, "R2 reset irq", data_irq, 0);
        chk(timeout_flag == 0, "R5 reset timeout", timeout_flag, 0);
        chk(overrun_flag == 0, "R9 reset overrun", overrun_flag, 0);

        fifo_en = 1;
        step();
        // Trigger level 1.
        trig_code = 0;
        push_byte(8'h11);
        chk(data_irq == 1, "R2 code0 level1", data_irq, 1);
        pop_byte();
        chk(data_irq == 0, "R2 code0 drained", data_irq, 0);

        // Trigger level 8, then fill to capacity and overrun.
        trig_code = 2;
        for (int i = 0; i < 7; i++) push_byte(8'(8'h20 + i));
        chk(data_irq == 0, "R2 code2 below", data_irq, 0);
        push_byte(8'h27);
        chk(data_irq == 1, "R2 code2 reached", data_irq, 1);
        for (int i = 0; i < 8; i++) push_byte(8'(8'h40 + i));
        chk(fill_count == 16, "R3 stored past trigger", fill_count, 16);
        push_byte(8'hEE);
        chk(fill_count == 16, "R9 full push dropped", fill_count, 16);
        chk(overrun_flag == 1, "R9 overrun set", overrun_flag, 1);
        pop_byte();
        chk(data_irq == 1, "R4 one read keeps irq", data_irq, 1);
        for (int i = 0; i < 7; i++) pop_byte();
        chk(fill_count == 8 && data_irq == 1, "R4 at level", data_irq, 1);
        pop_byte();
        chk(data_irq == 0, "R4 below level", data_irq, 0);
        while (exp_q.size() > 0) pop_byte();
        chk(fill_count == 0, "R1 drained", fill_count, 0);
        pop_byte();
        chk(fill_count == 0, "R10 empty read", fill_count, 0);
        chk(overrun_flag == 1, "R9 overrun sticky", overrun_flag, 1);
        do_flush();
        chk(overrun_flag == 0, "R8 flush clears overrun", overrun_flag, 0);

        // Trigger level 14 and level 4 on the same contents.
        trig_code = 3;
        for (int i = 0; i < 13; i++) push_byte(8'(8'h60 + i));
        chk(data_irq == 0, "R2 code3 below", data_irq, 0);
        push_byte(8'h6D);
        chk(data_irq == 1, "R2 code3 reached", data_irq, 1);
        trig_code = 1;
        step();
        chk(data_irq == 1, "R2 code1 level4", data_irq, 1);
        do_flush();
        chk(fill_count == 0, "R8 flush empties", fill_count, 0);
        flush = 1; push_valid = 1; push_data = 8'h99;
        step();
        flush = 0; push_valid = 0;
        chk(fill_count == 0, "R8 push with flush discarded", fill_count, 0);

        // Idle timeout.
        trig_code = 3;
        push_byte(8'h71);
        push_byte(8'h72);
        for (int i = 0; i < 3; i++) tick();
        chk(timeout_flag == 0, "R5 three ticks", timeout_flag, 0);
        push_byte(8'h73);
        for (int i = 0; i < 3; i++) tick();
        chk(timeout_flag == 0, "R6 push restarts", timeout_flag, 0);
        tick();
        chk(timeout_flag == 1, "R5 timeout set", timeout_flag, 1);
        chk(data_irq == 1, "R5 irq with timeout", data_irq, 1);
        pop_byte();
        chk(timeout_flag == 0, "R6 read clears timeout", timeout_flag, 0);
        chk(data_irq == 0, "R6 irq drops after read", data_irq, 0);
        for (int i = 0; i < 4; i++) tick();
        chk(timeout_flag == 1, "R5 timeout again", timeout_flag, 1);
        while (exp_q.size() > 0) pop_byte();

        // Single holding byte mode.
        fifo_en = 0;
        exp_q.delete();
        step();
        chk(fill_count == 0, "R8 mode change empties", fill_count, 0);
        push_byte(8'hA5);
        chk(fill_count == 1 && data_irq == 1, "R7 irq per byte", data_irq, 1);
        push_byte(8'h5A);
        chk(fill_count == 1, "R7 holds one byte", fill_count, 1);
        chk(overrun_flag == 1, "R9 overrun in single mode", overrun_flag, 1);
        pop_byte();
        chk(fill_count == 0 && data_irq == 0, "R7 irq cleared", data_irq, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule